// File: doc/BRIEF.md
# Four-Switch Buck-Boost Mode Sequencer

This block decides, once per switching period, which way a non-inverting four-switch buck-boost power stage should run, and then drives the four switch enables for that period. The stage has an input leg and an output leg. The input leg has a high switch to the input rail and a low switch to ground. The output leg has a low switch to ground and a high switch to the output rail. The block compares the digital codes for the input and output voltage and picks one of three modes: step-down, step-up, or a mixed mode that runs both legs within each period.

Mode changes use hysteresis and happen only at a period boundary. The block normally moves one mode step per period. The exception is a start-up request. Until the output code comes close to the target code, a start-up request holds the stage in step-up mode, whatever the input code is. Each leg gets a fixed dead time between its two complementary switches. The duty command is a fraction of the period and is sampled once per period.

Top module: `bbModeSeq`

## Requirements
- R1: While reset is held, and for DEAD clocks after it is released, all four switch enables are 0. The mode output reads 0 during reset.
- R2: The mode output encodes mixed mode as 0, step-down as 1 and step-up as 2. A period is 2**CNT_W clocks (64 by default). The mode and the duty command are sampled in the last clock of a period and take effect on the first clock of the next period. Changes to the duty command in the middle of a period have no effect on the current period.
- R3: With d = vin - vout, mixed mode moves to step-down when d >= BUCK_ON (48). Step-down returns to mixed mode when d < BUCK_OFF (24).
- R4: With e = vout - vin, mixed mode moves to step-up when e >= BOOST_ON (48). Step-up returns to mixed mode when e < BOOST_OFF (24).
- R5: Apart from the start-up override, the mode never moves directly between step-down and step-up.
- R6: A 1 on startReq in any clock arms start-up. At each boundary, while start-up is armed and vout + NEAR < target (NEAR = 16), the next mode is step-up. Start-up disarms at the first boundary where vout + NEAR >= target, and the normal hysteresis rules then apply from the current mode.
- R7: In step-down mode, the input high switch is on while the period count is below the duty. The input low switch is its complement. The output high switch stays on and the output low switch stays off.
- R8: In step-up mode, the input high switch stays on and the input low switch stays off. The output low switch is on while the period count is below the duty. The output high switch is its complement.
- R9: In mixed mode, the first half-period is a step-down phase and the second half-period is a step-up phase. In each phase, the active leg is on while the count within that half is below duty/2 (integer division).
- R10: Neither leg ever has both of its switches on. When the requested state of a leg changes, that leg has both switches off for exactly DEAD (2) clocks, and the newly requested switch turns on after that. Each switch enable lags its request by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vinCode | input | CODE_W | Input voltage code |
| voutCode | input | CODE_W | Output voltage code |
| targetCode | input | CODE_W | Output target code |
| dutyCmd | input | CNT_W | Duty command in period clocks |
| startReq | input | 1 | Start-up request (arms forced step-up) |
| swInHi | output | 1 | Input leg high switch enable |
| swInLo | output | 1 | Input leg low switch enable |
| swOutLo | output | 1 | Output leg low switch enable |
| swOutHi | output | 1 | Output leg high switch enable |
| modeOut | output | 2 | Current mode (0 mixed, 1 step-down, 2 step-up) |

## Verification
Two functions can act at the same boundary: the start-up override and a hysteretic threshold crossing. The bench provokes this by pulsing startReq while the input code sits far above the output code, which would otherwise call for step-down. It judges the outcome by requiring step-up, including a direct jump from step-down. A second coincidence occurs when a mode change lands in the middle of a leg's dead-time window. Random voltage steps are placed near the thresholds, and the duty is changed in the middle of a period. Each clock, the bench compares every switch enable and the mode against a model that keeps its own period and dead-time count.

// File: rtl/bbseq_pkg.sv
package bbseq_pkg;
  typedef enum logic [1:0] {
    MODE_BB    = 2'd0,
    MODE_BUCK  = 2'd1,
    MODE_BOOST = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  loadDuty;
  } seqCtl_t;
endpackage

// File: rtl/bbDeadLeg.sv
module bbDeadLeg #(
  parameter int DEAD = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  output logic hiOn,
  output logic loOn
);
  localparam int DT_W = $clog2(DEAD + 1);
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD);

  logic            reqQ;
  logic [DT_W-1:0] dtCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      dtCnt <= DT_LOAD;
    end else begin
      reqQ <= req;
      if (req != reqQ) dtCnt <= DT_LOAD;
      else if (dtCnt != '0) dtCnt <= dtCnt - 1'b1;
    end
  end

  assign hiOn = reqQ && (dtCnt == '0);
  assign loOn = !reqQ && (dtCnt == '0);
endmodule

// File: rtl/bbSeqPath.sv
module bbSeqPath
  import bbseq_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DEAD  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [CNT_W-1:0] dutyCmd,
  output logic             periodEnd,
  output logic             swInHi,
  output logic             swInLo,
  output logic             swOutLo,
  output logic             swOutHi
);
  localparam int HALF_W = CNT_W - 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  dutyQ;
  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] halfDuty;
  logic              secondHalf;
  logic              inReq;
  logic              outReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dutyQ <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (ctl.loadDuty) dutyQ <= dutyCmd;
    end
  end

  assign periodEnd  = (cnt == {CNT_W{1'b1}});
  assign halfCnt    = cnt[HALF_W-1:0];
  assign halfDuty   = dutyQ[CNT_W-1:1];
  assign secondHalf = cnt[CNT_W-1];

  always_comb begin
    inReq  = 1'b0;
    outReq = 1'b0;
    unique case (ctl.mode)
      MODE_BUCK: begin
        inReq  = (cnt < dutyQ);
        outReq = 1'b0;
      end
      MODE_BOOST: begin
        inReq  = 1'b1;
        outReq = (cnt < dutyQ);
      end
      default: begin
        if (secondHalf) begin
          inReq  = 1'b1;
          outReq = (halfCnt < halfDuty);
        end else begin
          inReq  = (halfCnt < halfDuty);
          outReq = 1'b0;
        end
      end
    endcase
  end

  bbDeadLeg #(.DEAD(DEAD)) inLeg (
    .clk(clk), .rstN(rstN), .req(inReq), .hiOn(swInHi), .loOn(swInLo)
  );

  bbDeadLeg #(.DEAD(DEAD)) outLeg (
    .clk(clk), .rstN(rstN), .req(outReq), .hiOn(swOutLo), .loOn(swOutHi)
  );
endmodule

// File: rtl/bbSeqCtrl.sv
module bbSeqCtrl
  import bbseq_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int BUCK_ON   = 48,
  parameter int BUCK_OFF  = 24,
  parameter int BOOST_ON  = 48,
  parameter int BOOST_OFF = 24,
  parameter int NEAR      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodEnd,
  input  logic [CODE_W-1:0] vinCode,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              startReq,
  output seqCtl_t           ctl,
  output logic              forceBoost
);
  localparam int SW = CODE_W + 2;

  mode_e          modeQ;
  mode_e          modeNx;
  logic           startArmed;
  logic           armedNow;
  logic           nearTarget;
  logic signed [SW-1:0] dIn;
  logic signed [SW-1:0] dOut;
  logic [SW-1:0]  voutPlus;

  assign dIn        = $signed({2'b00, vinCode}) - $signed({2'b00, voutCode});
  assign dOut       = -dIn;
  assign voutPlus   = {2'b00, voutCode} + SW'(NEAR);
  assign nearTarget = (voutPlus >= {2'b00, targetCode});
  assign armedNow   = startArmed || startReq;
  assign forceBoost = armedNow && !nearTarget;

  always_comb begin
    modeNx = modeQ;
    if (forceBoost) begin
      modeNx = MODE_BOOST;
    end else begin
      unique case (modeQ)
        MODE_BUCK:  if (dIn < BUCK_OFF) modeNx = MODE_BB;
        MODE_BOOST: if (dOut < BOOST_OFF) modeNx = MODE_BB;
        default: begin
          if (dIn >= BUCK_ON)        modeNx = MODE_BUCK;
          else if (dOut >= BOOST_ON) modeNx = MODE_BOOST;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= MODE_BB;
      startArmed <= 1'b0;
    end else if (periodEnd) begin
      modeQ      <= modeNx;
      startArmed <= forceBoost;
    end else begin
      startArmed <= armedNow;
    end
  end

  assign ctl.mode     = modeQ;
  assign ctl.loadDuty = periodEnd;
endmodule

// File: rtl/bbModeSeq.sv
module bbModeSeq
  import bbseq_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 6,
  parameter int DEAD      = 2,
  parameter int BUCK_ON   = 48,
  parameter int BUCK_OFF  = 24,
  parameter int BOOST_ON  = 48,
  parameter int BOOST_OFF = 24,
  parameter int NEAR      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] vinCode,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [CNT_W-1:0]  dutyCmd,
  input  logic              startReq,
  output logic              swInHi,
  output logic              swInLo,
  output logic              swOutLo,
  output logic              swOutHi,
  output logic [1:0]        modeOut
);
  seqCtl_t ctl;
  logic    periodEnd;
  logic    forceBoost;

  bbSeqCtrl #(
    .CODE_W(CODE_W), .BUCK_ON(BUCK_ON), .BUCK_OFF(BUCK_OFF),
    .BOOST_ON(BOOST_ON), .BOOST_OFF(BOOST_OFF), .NEAR(NEAR)
  ) ctrl (
    .clk(clk), .rstN(rstN), .periodEnd(periodEnd),
    .vinCode(vinCode), .voutCode(voutCode), .targetCode(targetCode),
    .startReq(startReq), .ctl(ctl), .forceBoost(forceBoost)
  );

  bbSeqPath #(.CNT_W(CNT_W), .DEAD(DEAD)) path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dutyCmd(dutyCmd),
    .periodEnd(periodEnd), .swInHi(swInHi), .swInLo(swInLo),
    .swOutLo(swOutLo), .swOutHi(swOutHi)
  );

  assign modeOut = ctl.mode;
endmodule

// File: rtl/bbModeSeqChk.sv
module bbModeSeqChk #(
  parameter int DEAD = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       swInHi,
  input logic       swInLo,
  input logic       swOutLo,
  input logic       swOutHi,
  input logic [1:0] modeOut,
  input logic       periodEnd,
  input logic       forceBoost
);
  logic [1:0] modePrev;
  logic [7:0] ageQ;
  logic [7:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev <= 2'd0;
      ageQ     <= 8'd0;
    end else begin
      modePrev <= modeOut;
      if (age != 8'hff) ageQ <= age + 8'd1;
      else ageQ <= age;
    end
  end

  assign age = (modeOut != modePrev) ? 8'd0 : ageQ;

  AST_IN_LEG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(swInHi && swInLo)); // R10
  AST_OUT_LEG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(swOutHi && swOutLo)); // R10
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != $past(modeOut)) |-> $past(periodEnd)); // R2
  AST_NO_DIRECT_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2 && $past(modeOut) == 2'd1) |-> $past(forceBoost)); // R5
  AST_NO_DOWN_FROM_UP: assert property (@(posedge clk) disable iff (!rstN)
    !(modeOut == 2'd1 && $past(modeOut) == 2'd2)); // R5
  AST_BUCK_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && int'(age) > DEAD) |-> (swOutHi && !swOutLo)); // R7
  AST_BOOST_IN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2 && int'(age) > DEAD) |-> (swInHi && !swInLo)); // R8
  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd3); // R2
endmodule

bind bbModeSeq bbModeSeqChk #(.DEAD(DEAD)) chk (
  .clk(clk), .rstN(rstN), .swInHi(swInHi), .swInLo(swInLo),
  .swOutLo(swOutLo), .swOutHi(swOutHi), .modeOut(modeOut),
  .periodEnd(periodEnd), .forceBoost(forceBoost)
);

// File: tb/bbModeSeq_test.sv
module bbModeSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 10;
  localparam int CNT_W = 6;
  localparam int DEAD = 2;
  localparam int PER = 1 << CNT_W;
  localparam int BUCK_ON = 48, BUCK_OFF = 24, BOOST_ON = 48, BOOST_OFF = 24, NEAR = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CODE_W-1:0] vinCode = 10'd500, voutCode = 10'd500, targetCode = 10'd500;
  logic [CNT_W-1:0] dutyCmd = '0;
  logic startReq = 1'b0;
  logic swInHi, swInLo, swOutLo, swOutHi;
  logic [1:0] modeOut;

  int checks = 0;
  int errors = 0;

  bbModeSeq uut (
    .clk(clk), .rstN(rstN), .vinCode(vinCode), .voutCode(voutCode),
    .targetCode(targetCode), .dutyCmd(dutyCmd), .startReq(startReq),
    .swInHi(swInHi), .swInLo(swInLo), .swOutLo(swOutLo), .swOutHi(swOutHi),
    .modeOut(modeOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int mCnt, mMode, mDuty, mArm, aQ, aDt, cQ, cDt;
  string mWhy = "R2";

  function automatic int nextMode(int m, int vi, int vo);
    int d = vi - vo;
    case (m)
      1: return (d < BUCK_OFF) ? 0 : 1;
      2: return ((-d) < BOOST_OFF) ? 0 : 2;
      default: begin
        if (d >= BUCK_ON) return 1;
        if ((-d) >= BOOST_ON) return 2;
        return 0;
      end
    endcase
  endfunction

  function automatic string transTag(int from, int to);
    if (from == to) return "R2";
    if (from == 1 || to == 1) return "R3";
    return "R4";
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mMode = 0; mDuty = 0; mArm = 0;
      aQ = 0; aDt = DEAD; cQ = 0; cDt = DEAD; mWhy = "R1";
    end else begin
      int aReq, cReq, hc, hd;
      hc = mCnt % (PER/2); hd = mDuty / 2;
      if (mMode == 1) begin aReq = (mCnt < mDuty); cReq = 0; end
      else if (mMode == 2) begin aReq = 1; cReq = (mCnt < mDuty); end
      else if (mCnt >= PER/2) begin aReq = 1; cReq = (hc < hd); end
      else begin aReq = (hc < hd); cReq = 0; end
      if (aReq != aQ) aDt = DEAD; else if (aDt > 0) aDt--;
      aQ = aReq;
      if (cReq != cQ) cDt = DEAD; else if (cDt > 0) cDt--;
      cQ = cReq;
      if (mCnt == PER-1) begin
        int arm, near, nm;
        arm  = mArm | int'(startReq);
        near = (int'(voutCode) + NEAR >= int'(targetCode));
        if (arm && !near) begin nm = 2; mArm = 1; mWhy = "R6"; end
        else begin nm = nextMode(mMode, vinCode, voutCode); mArm = 0; mWhy = transTag(mMode, nm); end
        mMode = nm;
        mDuty = dutyCmd;
      end else begin
        mArm = mArm | int'(startReq);
      end
      mCnt = (mCnt + 1) % PER;
    end
  end

  task automatic check1(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string swTag(int m);
    if (m == 1) return "R7";
    if (m == 2) return "R8";
    return "R9";
  endfunction

  task automatic checkCycle();
    string st = (!rstN) ? "R1" : swTag(mMode);
    check1({mWhy, " mode"}, int'(modeOut), mMode);
    check1({st, " R10 inHi"},  int'(swInHi),  int'(aQ == 1 && aDt == 0));
    check1({st, " R10 inLo"},  int'(swInLo),  int'(aQ == 0 && aDt == 0));
    check1({st, " R10 outLo"}, int'(swOutLo), int'(cQ == 1 && cDt == 0));
    check1({st, " R10 outHi"}, int'(swOutHi), int'(cQ == 0 && cDt == 0));
    check1("R10 exclusive", int'((swInHi && swInLo) || (swOutHi && swOutLo)), 0);
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkCycle();
      startReq = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      check1("R1 reset mode", int'(modeOut), 0);
      check1("R1 reset switches", int'({swInHi, swInLo, swOutLo, swOutHi}), 0);
    end
    rstN = 1'b1;
    dutyCmd = 6'd20;
    runCycles(DEAD);  // R1 off after release
    runCycles(2*PER);
    // R6 with R3 coincident: input far above output but start-up armed
    vinCode = 10'd700; voutCode = 10'd300; targetCode = 10'd600;
    @(negedge clk); startReq = 1'b1;
    runCycles(3*PER);
    voutCode = 10'd590;       // near target: normal hysteresis resumes
    runCycles(3*PER);
    // step-down reached, then start-up forces a direct jump (R5 exception)
    vinCode = 10'd900; voutCode = 10'd400; targetCode = 10'd800;
    runCycles(2*PER);
    @(negedge clk); startReq = 1'b1;
    runCycles(2*PER);
    targetCode = 10'd300;
    // R4 hysteresis edges, duty extremes
    vinCode = 10'd400; voutCode = 10'd448; dutyCmd = 6'd63;
    runCycles(2*PER);
    voutCode = 10'd424; runCycles(2*PER);  // e=24 stays step-up
    voutCode = 10'd423; dutyCmd = 6'd0; runCycles(2*PER);  // e=23 back to mixed
    // R3 hysteresis edges
    vinCode = 10'd448; voutCode = 10'd400; dutyCmd = 6'd1; runCycles(2*PER);
    vinCode = 10'd424; runCycles(2*PER);
    vinCode = 10'd423; runCycles(2*PER);
    // constrained random
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      checkCycle();
      startReq = 1'b0;
      if ($urandom_range(39) == 0) begin
        int vo = $urandom_range(800, 200);
        int dd = int'($urandom_range(160)) - 80;
        voutCode = CODE_W'(vo);
        vinCode  = CODE_W'(vo + dd);
      end
      if ($urandom_range(15) == 0) dutyCmd = CNT_W'($urandom);
      if ($urandom_range(400) == 0) begin
        startReq = 1'b1;
        targetCode = CODE_W'($urandom_range(900, 100));
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule